// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Receiver

This block turns a three-wire stereo audio stream (bit clock, frame clock, serial data) into parallel words. It runs on a system clock fast enough to oversample the bit clock. The two serial clocks and the data line pass through two-stage synchronizers. A rising edge of the bit clock becomes a one-cycle bit tick, and all capture work happens on those ticks.

One capture engine handles five framings, picked by a 3-bit format input:

| Code | Framing |
|------|---------|
| 0 | 16-bit right-justified |
| 1 | 20-bit right-justified |
| 2 | 24-bit left-justified (default) |
| 3 | 24-bit I2S-style, MSB one bit late |
| 4 | 24-bit right-justified |

- Right-justified framings keep a running shift register and take its last N bits when the frame clock changes level.
- Left-justified framings count bits from the frame clock change and keep at most 24.

Every result leaves the block as a 24-bit two's-complement word. After both channels of a frame are in, a one-cycle strobe marks the pair.

Top module: `stereo_serial_rx`

## Requirements
- R1: While `rst_n` is low, `left_word` and `right_word` are zero and `word_valid` is low.
- R2: In format 2, a half-frame begins at the first bit tick that sees a new frame-clock level; that bit is the MSB. Up to 24 bits are kept, and later bits in the half-frame are ignored. Frame clock high carries the left channel.
- R3: In format 2, a half-frame with fewer than 24 bits (16 bits at 32 bit clocks per frame) yields those bits left-aligned, with zeros in the unused LSBs.
- R4: In format 3, the bit on the tick where the frame clock changes is ignored. The MSB is on the next tick and 24 bits are kept. Frame clock low carries the left channel.
- R5: In format 4, the word is the last 24 bits received before the frame-clock change, and earlier bits are ignored. Frame clock high carries the left channel.
- R6: In format 1, the word is the last 20 bits before the frame-clock change, sign-extended from bit 19 to 24 bits.
- R7: In format 0, the word is the last 16 bits before the frame-clock change, sign-extended from bit 15. This works at both 64 and 32 bit clocks per frame.
- R8: `word_valid` is a single-cycle pulse. It is raised in the cycle `right_word` takes a new word, and only if a left word was stored since the previous pulse.
- R9: `left_word`, `right_word` and `word_valid` change only in the cycle after a bit tick.
- R10: Format codes 5, 6 and 7 behave as format 2.
- R11: Nothing is stored until the first frame-clock change after reset, so the partial half-frame in progress at reset release is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversampling the serial clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 3 | Framing format code |
| bclk_in | input | 1 | Serial bit clock, data taken on its rising edge |
| fclk_in | input | 1 | Frame clock, its level selects the channel |
| sdata_in | input | 1 | Serial data, MSB first, two's complement |
| left_word | output | 24 | Last left-channel word, 24-bit two's complement |
| right_word | output | 24 | Last right-channel word, 24-bit two's complement |
| word_valid | output | 1 | One-cycle strobe when a left/right pair is complete |

## Verification
In the left-justified format, one bit tick does two jobs at once: it closes the finished half-frame's word and captures the MSB of the new half-frame. Any slip there either loses the new MSB or smears it into the old word.

The bench provokes this by streaming frames whose first and last bits are ones against distinct neighbours. It then compares both captured words exactly with values computed from the format rules.

The same tick also carries the right-channel store and the pair strobe. So each frame checks that exactly one strobe appears and that it carries the newly stored right word.

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        fmt_sel,
  input  logic              bclk_in,
  input  logic              fclk_in,
  input  logic              sdata_in,
  output logic [WORD_W-1:0] left_word,
  output logic [WORD_W-1:0] right_word,
  output logic              word_valid
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [2:0] bclk_q;
  logic [1:0] fclk_q, sd_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bclk_q <= '0;
      fclk_q <= '0;
      sd_q   <= '0;
    end else begin
      bclk_q <= {bclk_q[1:0], bclk_in};
      fclk_q <= {fclk_q[0], fclk_in};
      sd_q   <= {sd_q[0], sdata_in};
    end

  wire bit_tick = bclk_q[1] & ~bclk_q[2];
  wire fclk_now = fclk_q[1];
  wire sd_now   = sd_q[1];

  logic [2:0] fmt_eff;
  assign fmt_eff = (fmt_sel > 3'd4) ? 3'd2 : fmt_sel;
  wire is_rj  = (fmt_eff == 3'd0) | (fmt_eff == 3'd1) | (fmt_eff == 3'd4);
  wire is_i2s = (fmt_eff == 3'd3);

  logic              fclk_prev, armed, started, have_left;
  logic [WORD_W-1:0] shreg, acc;
  logic [CNT_W-1:0]  cnt;

  wire half_end  = bit_tick & armed & (fclk_now != fclk_prev);
  wire end_left  = is_i2s ? ~fclk_prev : fclk_prev;

  logic [WORD_W-1:0] rj_word, lj_word, captured;
  logic [CNT_W-1:0]  shamt;

  always_comb begin
    case (fmt_eff)
      3'd0:    rj_word = {{(WORD_W-16){shreg[15]}}, shreg[15:0]};
      3'd1:    rj_word = {{(WORD_W-20){shreg[19]}}, shreg[19:0]};
      default: rj_word = shreg;
    endcase
    shamt    = FULL - cnt;
    lj_word  = (cnt >= FULL) ? acc : (acc << shamt);
    captured = is_rj ? rj_word : lj_word;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fclk_prev  <= 1'b0;
      armed      <= 1'b0;
      started    <= 1'b0;
      have_left  <= 1'b0;
      shreg      <= '0;
      acc        <= '0;
      cnt        <= '0;
      left_word  <= '0;
      right_word <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (bit_tick) begin
        fclk_prev <= fclk_now;
        armed     <= 1'b1;
        shreg     <= {shreg[WORD_W-2:0], sd_now};
        if (half_end) begin
          started <= 1'b1;
          if (is_i2s) begin
            acc <= '0;
            cnt <= '0;
          end else begin
            acc <= {{(WORD_W-1){1'b0}}, sd_now};
            cnt <= CNT_W'(1);
          end
          if (started) begin
            if (end_left) begin
              left_word <= captured;
              have_left <= 1'b1;
            end else begin
              right_word <= captured;
              if (have_left) begin
                word_valid <= 1'b1;
                have_left  <= 1'b0;
              end
            end
          end
        end else if (cnt < FULL) begin
          acc <= {acc[WORD_W-2:0], sd_now};
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
endmodule

// File: rtl/stereo_serial_rx_chk.sv
module stereo_serial_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  fmt_sel,
  input logic        bit_tick,
  input logic [23:0] left_word,
  input logic [23:0] right_word,
  input logic        word_valid
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (left_word == '0 && right_word == '0 && !word_valid));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  a_r9_quiet_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> ($stable(left_word) && $stable(right_word) && !word_valid));

  a_r7_sign16: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && $past(fmt_sel) == 3'd0) |->
      (right_word[23:15] == 9'h000 || right_word[23:15] == 9'h1FF));

  a_r6_sign20: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && $past(fmt_sel) == 3'd1) |->
      (right_word[23:19] == 5'h00 || right_word[23:19] == 5'h1F));
endmodule

bind stereo_serial_rx stereo_serial_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .bit_tick(bit_tick),
  .left_word(left_word), .right_word(right_word), .word_valid(word_valid)
);

// File: tb/stereo_serial_rx_tb.sv
`timescale 1ns/1ps
module stereo_serial_rx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] fmt_sel = 3'd2;
  logic bclk = 1'b0, fclk = 1'b0, sdata = 1'b0;
  logic [23:0] left_word, right_word;
  logic word_valid;

  int n_tests = 0, n_fail = 0;
  int n_valid = 0;
  logic [23:0] got_l, got_r;

  always #5 clk = ~clk;

  stereo_serial_rx u_dut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .bclk_in(bclk),
    .fclk_in(fclk), .sdata_in(sdata), .left_word(left_word),
    .right_word(right_word), .word_valid(word_valid)
  );

  always @(negedge clk)
    if (word_valid) begin
      n_valid++;
      got_l = left_word;
      got_r = right_word;
    end

  localparam int NV = 12;
  localparam logic [2:0]  V_FMT [NV] = '{3'd2, 3'd2, 3'd2, 3'd3, 3'd3, 3'd4,
                                         3'd1, 3'd0, 3'd0, 3'd5, 3'd7, 3'd4};
  localparam int          V_HALF[NV] = '{32, 32, 16, 32, 32, 32, 32, 32, 16, 32, 32, 32};
  localparam logic [23:0] V_L   [NV] = '{24'h123456, 24'h800000, 24'hA5C3FF, 24'h0F1E2D,
                                         24'h800001, 24'h13579B, 24'h08ABCD, 24'h007FFF,
                                         24'h00ABCD, 24'h654321, 24'h000001, 24'hFFFFFF};
  localparam logic [23:0] V_R   [NV] = '{24'hFEDCBA, 24'h7FFFFF, 24'h5A3CFF, 24'hC3B4A5,
                                         24'h000001, 24'hECA864, 24'h034567, 24'h008000,
                                         24'h001234, 24'h9ABCDE, 24'hFFFFFE, 24'h000000};
  localparam logic [23:0] V_EL  [NV] = '{24'h123456, 24'h800000, 24'hA5C300, 24'h0F1E2D,
                                         24'h800001, 24'h13579B, 24'hF8ABCD, 24'h007FFF,
                                         24'hFFABCD, 24'h654321, 24'h000001, 24'hFFFFFF};
  localparam logic [23:0] V_ER  [NV] = '{24'hFEDCBA, 24'h7FFFFF, 24'h5A3C00, 24'hC3B4A5,
                                         24'h000001, 24'hECA864, 24'h034567, 24'hFF8000,
                                         24'h001234, 24'h9ABCDE, 24'hFFFFFE, 24'h000000};
  localparam string V_TAG[NV] = '{"R2", "R2", "R3", "R4", "R4", "R5",
                                  "R6", "R7", "R7", "R10", "R10", "R5"};

  task automatic check(input bit ok, input string tag, input logic [23:0] act,
                       input logic [23:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic ws, input logic b);
    @(negedge clk); bclk = 1'b0; fclk = ws; sdata = b;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic bit_at(input logic [2:0] f, input int n, input int i,
                                  input logic [23:0] w);
    int width;
    logic [2:0] fe;
    fe = (f > 3'd4) ? 3'd2 : f;
    if (fe == 3'd2) return (i < 24) ? w[23-i] : 1'b1;
    if (fe == 3'd3) return (i >= 1 && i <= 24) ? w[24-i] : 1'b1;
    width = (fe == 3'd0) ? 16 : (fe == 3'd1) ? 20 : 24;
    if (i >= n - width) return w[width-1-(i-(n-width))];
    return 1'b1;
  endfunction

  task automatic send_half(input logic [2:0] f, input int n, input bit is_left,
                           input logic [23:0] w);
    logic ws;
    ws = (f == 3'd3) ? ~is_left : is_left;
    for (int i = 0; i < n; i++) send_bit(ws, bit_at(f, n, i, w));
  endtask

  task automatic do_reset(input logic [2:0] f);
    rst_n = 1'b0; fmt_sel = f; bclk = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n_valid = 0;
  endtask

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    check(left_word == 0, "R1 left", left_word, 24'h0);
    check(right_word == 0 && !word_valid, "R1 right/valid", right_word, 24'h0);

    for (int v = 0; v < NV; v++) begin
      do_reset(V_FMT[v]);
      send_half(V_FMT[v], V_HALF[v], 1'b0, 24'hFFFFFF);
      send_half(V_FMT[v], V_HALF[v], 1'b1, V_L[v]);
      send_half(V_FMT[v], V_HALF[v], 1'b0, V_R[v]);
      send_half(V_FMT[v], 4, 1'b1, 24'h000000);
      repeat (10) @(negedge clk);
      // R11: preamble half yields nothing, one pair per frame
      check(n_valid == 1, {V_TAG[v], " R11 pulse count"}, 24'(n_valid), 24'd1);
      check(got_l == V_EL[v], {V_TAG[v], " left"}, got_l, V_EL[v]);
      check(got_r == V_ER[v], {V_TAG[v], " right"}, got_r, V_ER[v]);
    end

    // R8: right word without a prior left word gives no pulse
    do_reset(3'd2);
    send_half(3'd2, 32, 1'b1, 24'h111111);
    send_half(3'd2, 32, 1'b0, 24'h222222);
    send_half(3'd2, 4, 1'b1, 24'h0);
    repeat (10) @(negedge clk);
    check(n_valid == 0, "R8 no pulse without left", 24'(n_valid), 24'd0);
    check(right_word == 24'h222222, "R8 right stored", right_word, 24'h222222);

    // R8: back-to-back frames give two pulses, last pair wins
    do_reset(3'd4);
    send_half(3'd4, 32, 1'b0, 24'h0);
    send_half(3'd4, 32, 1'b1, 24'hAAAAAA);
    send_half(3'd4, 32, 1'b0, 24'h555555);
    send_half(3'd4, 32, 1'b1, 24'h0C0C0C);
    send_half(3'd4, 32, 1'b0, 24'hC0C0C0);
    send_half(3'd4, 4, 1'b1, 24'h0);
    repeat (10) @(negedge clk);
    check(n_valid == 2, "R8 two pulses", 24'(n_valid), 24'd2);
    check(got_l == 24'h0C0C0C && got_r == 24'hC0C0C0, "R8 second pair", got_r, 24'hC0C0C0);

    // R9: activity on frame clock and data without bit clock changes nothing
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); fclk = k[0]; sdata = k[1];
    end
    repeat (10) @(negedge clk);
    check(left_word == 24'h0C0C0C && n_valid == 2, "R9 left held", left_word, 24'h0C0C0C);
    check(right_word == 24'hC0C0C0, "R9 right held", right_word, 24'hC0C0C0);

    // R1: reset clears stored words
    rst_n = 1'b0;
    @(negedge clk);
    check(left_word == 0 && right_word == 0, "R1 clear after use", left_word, 24'h0);
    rst_n = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule